// File: doc/BRIEF.md
# Rotational Sector Tracker

This block follows the angular position of a spinning disk by watching two pulse lines from the drive. The revolution marker fires once per turn. The boundary marker fires at the start of every sector. Both lines idle high at the pins and go low while they are active. Inside the block each line is inverted, passed through a synchroniser and reduced to a single-cycle rising-edge event. The revolution event sets a free-running sector counter back to zero. Each boundary event moves the counter forward by one.

A controller can name a sector it wants and arm a request. When the counter reaches that sector, the block issues a one-cycle match strobe and disarms the request. The current sector number and a valid flag are always visible. A sticky overrun flag reports a track that delivered more boundary pulses than it has sectors.

Top module: `sector_tracker`

## Requirements
- R1: Both pulse lines are active-low at the pins. An event is taken only on the high-to-low pin transition. A pulse held low for many cycles produces exactly one event.
- R2: After reset, sector_o is 0 and valid_o, match_o and overrun_o are all 0.
- R3: A revolution event sets sector_o to 0 and valid_o to 1.
- R4: While valid_o is 1, each boundary event raises sector_o by one. The value stays in the range 0 to SECTORS-1.
- R5: Boundary events that arrive before the first revolution event are ignored. sector_o stays 0 and valid_o stays 0.
- R6: A request is armed by a one-cycle tgt_load_i, which also captures tgt_sector_i. On the event whose new count equals the armed target, match_o is high for exactly one cycle. Either kind of event counts, so a revolution event can match target 0.
- R7: A match disarms the request. When the same sector comes round again without a new load, no further strobe is issued.
- R8: match_o is never high while valid_o is low, and never high without an armed request.
- R9: A boundary event that arrives while sector_o equals SECTORS-1 wraps the count to 0 and sets overrun_o. overrun_o then stays set until reset.
- R10: When both lines fall in the same cycle, the revolution event wins and the count becomes 0.
- R11: With two synchroniser stages, a pin that falls before clock edge k changes sector_o after edge k+2. The value seen after edge k+1 is still the old one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| index_n_i | input | 1 | Revolution marker from the drive, active low |
| sector_n_i | input | 1 | Sector boundary marker from the drive, active low |
| tgt_load_i | input | 1 | One-cycle strobe that captures the target and arms a request |
| tgt_sector_i | input | CW | Wanted sector number |
| sector_o | output | CW | Current sector number |
| valid_o | output | 1 | Set once a revolution marker has been seen |
| match_o | output | 1 | One-cycle strobe when the wanted sector begins |
| overrun_o | output | 1 | Sticky flag for too many boundary pulses in one revolution |

## Verification
The hardest state to reach is the overrun condition. A boundary pulse has to arrive while the count already sits at its last sector, and no revolution marker may come in between. Random traffic seldom produces that, so a directed sequence sends SECTORS-1 boundary pulses after one revolution marker and then one more. Directed cases also cover the cycle-exact latency, a simultaneous fall of both lines, and a disarmed target coming round again. Around these, seeded random traffic mixes revolution markers, boundary pulses and fresh target loads, and a bench model predicts the count, the flags and the number of match strobes.

// File: rtl/sector_tracker_pkg.sv
package sector_tracker_pkg;

    // Line positions inside the synchroniser vector
    localparam int LINE_REV  = 0;
    localparam int LINE_BND  = 1;
    localparam int NUM_LINES = 2;

endpackage

// File: rtl/sector_tracker_edge.sv
module sector_tracker_edge #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [LINES-1:0] pin_n_i,
    output logic [LINES-1:0] rise_o
);

    typedef struct packed {
        logic [STAGES-1:0][LINES-1:0] sync;
        logic [LINES-1:0]             prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // invert at the boundary: active becomes 1
        st_d.sync[0] = ~pin_n_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d.sync[i] = st_q.sync[i-1];
        end
        st_d.prev = st_q.sync[STAGES-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rise_o = st_q.sync[STAGES-1] & ~st_q.prev;

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_line_chk
            // R1
            single_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                rise_o[g] |=> !rise_o[g]);
        end
    endgenerate

endmodule

// File: rtl/sector_tracker_count.sv
module sector_tracker_count #(
    parameter int SECTORS = 12,
    parameter int CW      = 4
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          rev_i,
    input  logic          bnd_i,
    output logic          evt_o,
    output logic [CW-1:0] nxt_cnt_o,
    output logic          nxt_valid_o,
    output logic [CW-1:0] cnt_o,
    output logic          valid_o,
    output logic          err_o
);

    localparam logic [CW-1:0] LAST = CW'(SECTORS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          valid;
        logic          err;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    evt_d;

    always_comb begin
        st_d  = st_q;
        evt_d = 1'b0;
        if (rev_i) begin
            st_d.cnt   = '0;
            st_d.valid = 1'b1;
            evt_d      = 1'b1;
        end else if (bnd_i && st_q.valid) begin
            evt_d = 1'b1;
            if (st_q.cnt == LAST) begin
                st_d.cnt = '0;
                st_d.err = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign evt_o       = evt_d;
    assign nxt_cnt_o   = st_d.cnt;
    assign nxt_valid_o = st_d.valid;
    assign cnt_o       = st_q.cnt;
    assign valid_o     = st_q.valid;
    assign err_o       = st_q.err;

    // R4
    cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_o <= LAST);
    // R5
    idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_o |-> cnt_o == '0);
    // R9
    err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |=> err_o);
    // R3
    rev_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rev_i |=> (cnt_o == '0) && valid_o);

endmodule

// File: rtl/sector_tracker_match.sv
module sector_tracker_match #(
    parameter int CW = 4
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          load_i,
    input  logic [CW-1:0] tgt_i,
    input  logic          evt_i,
    input  logic [CW-1:0] nxt_cnt_i,
    input  logic          nxt_valid_i,
    output logic          match_o
);

    typedef struct packed {
        logic [CW-1:0] tgt;
        logic          armed;
        logic          match;
    } mt_st_t;

    mt_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.match = evt_i && nxt_valid_i && st_q.armed && (nxt_cnt_i == st_q.tgt);
        if (st_d.match) begin
            st_d.armed = 1'b0;
        end
        if (load_i) begin
            st_d.tgt   = tgt_i;
            st_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign match_o = st_q.match;

    // R6
    match_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        match_o |=> !match_o);
    // R7
    disarm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (match_o && !$past(load_i)) |-> !st_q.armed);

endmodule

// File: rtl/sector_tracker.sv
module sector_tracker #(
    parameter int SECTORS     = 12,
    parameter int SYNC_STAGES = 2,
    localparam int CW         = (SECTORS > 1) ? $clog2(SECTORS) : 1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          index_n_i,
    input  logic          sector_n_i,
    input  logic          tgt_load_i,
    input  logic [CW-1:0] tgt_sector_i,
    output logic [CW-1:0] sector_o,
    output logic          valid_o,
    output logic          match_o,
    output logic          overrun_o
);

    import sector_tracker_pkg::*;

    logic [NUM_LINES-1:0] pins_n;
    logic [NUM_LINES-1:0] rises;
    logic                 evt;
    logic [CW-1:0]        nxt_cnt;
    logic                 nxt_valid;

    always_comb begin
        pins_n           = '1;
        pins_n[LINE_REV] = index_n_i;
        pins_n[LINE_BND] = sector_n_i;
    end

    sector_tracker_edge #(
        .LINES  (NUM_LINES),
        .STAGES (SYNC_STAGES)
    ) u_edge (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .pin_n_i (pins_n),
        .rise_o  (rises)
    );

    sector_tracker_count #(
        .SECTORS (SECTORS),
        .CW      (CW)
    ) u_count (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .rev_i       (rises[LINE_REV]),
        .bnd_i       (rises[LINE_BND]),
        .evt_o       (evt),
        .nxt_cnt_o   (nxt_cnt),
        .nxt_valid_o (nxt_valid),
        .cnt_o       (sector_o),
        .valid_o     (valid_o),
        .err_o       (overrun_o)
    );

    sector_tracker_match #(
        .CW (CW)
    ) u_match (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .load_i      (tgt_load_i),
        .tgt_i       (tgt_sector_i),
        .evt_i       (evt),
        .nxt_cnt_i   (nxt_cnt),
        .nxt_valid_i (nxt_valid),
        .match_o     (match_o)
    );

    // R8
    match_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        match_o |-> valid_o);

endmodule

// File: tb/sim_sector_tracker.sv
module sim_sector_tracker;

    localparam int SECTORS = 12;
    localparam int CW      = $clog2(SECTORS);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          idx_n = 1'b1;
    logic          sec_n = 1'b1;
    logic          load = 1'b0;
    logic [CW-1:0] tgt = '0;
    logic [CW-1:0] sector;
    logic          valid, match, overrun;

    int vectors = 0;
    int fails   = 0;
    int mcount  = 0;
    bit done    = 1'b0;

    // model state
    int m_cnt = 0;
    bit m_valid = 0, m_err = 0, m_armed = 0;
    int m_tgt = 0;

    always #2 clk = ~clk;

    sector_tracker #(.SECTORS(SECTORS)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .index_n_i(idx_n), .sector_n_i(sec_n),
        .tgt_load_i(load), .tgt_sector_i(tgt), .sector_o(sector),
        .valid_o(valid), .match_o(match), .overrun_o(overrun)
    );

    always @(negedge clk) if (match) mcount++;

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit model_event(input bit i, input bit s);
        bit ev, mt;
        ev = 0;
        if (i) begin
            m_cnt = 0; m_valid = 1; ev = 1;
        end else if (s && m_valid) begin
            ev = 1;
            if (m_cnt == SECTORS - 1) begin m_cnt = 0; m_err = 1; end
            else m_cnt = m_cnt + 1;
        end
        mt = ev && m_armed && (m_cnt == m_tgt);
        if (mt) m_armed = 0;
        return mt;
    endfunction

    task automatic do_load(input int t);
        @(negedge clk);
        load = 1'b1; tgt = CW'(t);
        @(negedge clk);
        load = 1'b0;
        m_tgt = t; m_armed = 1;
    endtask

    // one pulse on the chosen lines, held for several cycles
    task automatic pulse(input bit i, input bit s, input bit lat, input string req);
        int before_m, old_cnt;
        bit exp_m;
        old_cnt  = m_cnt;
        before_m = mcount;
        exp_m    = model_event(i, s);
        @(negedge clk);
        idx_n = ~i; sec_n = ~s;
        repeat (2) @(posedge clk);
        @(negedge clk);
        if (lat) chk("R11 old value", int'(sector), old_cnt);
        @(posedge clk);
        @(negedge clk);
        if (lat) chk("R11 new value", int'(sector), m_cnt);
        repeat (5) @(negedge clk);
        idx_n = 1'b1; sec_n = 1'b1;
        repeat (6) @(negedge clk);
        chk({req, " sector"}, int'(sector), m_cnt);
        chk({req, " valid"}, int'(valid), int'(m_valid));
        chk({req, " overrun R9"}, int'(overrun), int'(m_err));
        chk({req, " match count R6"}, mcount - before_m, int'(exp_m));
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R2 reset state
        chk("R2 sector", int'(sector), 0);
        chk("R2 valid", int'(valid), 0);
        chk("R2 match", int'(match), 0);
        chk("R2 overrun", int'(overrun), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R5 / R8: boundary pulses and an armed target before any revolution
        do_load(1);
        pulse(0, 1, 0, "R5 pre-index");
        pulse(0, 1, 0, "R8 pre-index");
        // R3: revolution marker
        pulse(1, 0, 0, "R3 index");
        // R6: armed target 1 matches on next boundary, R1 held pulse counts once
        pulse(0, 1, 0, "R6 R1 advance");
        // R11 latency on a plain advance, R4 counting
        pulse(0, 1, 1, "R4 R11 advance");
        // R7: target 1 comes round again without reload
        pulse(1, 0, 0, "R7 index");
        pulse(0, 1, 0, "R7 no rematch");
        // R6: target 0 matches on a revolution marker
        do_load(0);
        pulse(1, 0, 0, "R6 target zero");
        // R10: simultaneous fall
        pulse(0, 1, 0, "R10 setup");
        pulse(1, 1, 0, "R10 both lines");
        // R9: overrun after SECTORS-1 advances plus one
        do_load(0);
        for (int k = 0; k < SECTORS - 1; k++) pulse(0, 1, 0, "R4 fill");
        pulse(0, 1, 0, "R9 overrun wrap");
        pulse(1, 0, 0, "R9 sticky after index");
        // seeded random traffic
        for (int n = 0; n < 300; n++) begin
            int r;
            r = int'($urandom % 16);
            if (r == 0) pulse(1, 0, 0, "R3 random");
            else if (r == 1) do_load(int'($urandom % SECTORS));
            else if (r == 2) pulse(1, 1, 0, "R10 random");
            else pulse(0, 1, 0, "R4 random");
        end
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule